// File: doc/BRIEF.md
# Stopwatch and Time-of-Day Counter with Multiplexed Seven-Segment Drive

This block keeps a running time of hours, minutes, seconds and hundredths of a second. All of it runs from one system clock. Two free-running dividers produce single-cycle enables at the counting rate and at the display refresh rate. No derived clock is used.

The time is held as four BCD digit pairs. The pairs are chained so that each one advances only when the pair below it wraps. A run input gates the advance, and an asynchronous clear zeroes everything.

The eight digits share one segment bus. A three-bit digit index steps through the positions at the refresh rate, and the selected digit leaves the block already decoded to active-high segments. A chime output stays high for the whole second in which the seconds read 59, which gives one pulse per minute.

A library option lets the counting enable enter the chain at a higher pair. The pairs below that point then stay at zero, which makes a plain clock with no sub-second digits.

Top module: `stopwatch_core`

## Requirements
- R1: While `run` is high, the time advances by exactly one step of the lowest active pair every CLK_HZ/CNT_HZ clock cycles, which is 100000 by default. The divider keeps running while `run` is low.
- R2: `dig_sel` changes once every CLK_HZ/SCAN_HZ clock cycles, which is 10000 by default. Each change moves it up by one, and after 7 it returns to 0.
- R3: The value of `dig_sel` picks the digit on `seg`. Values 0 and 1 pick the hundredths and tenths digits, 2 and 3 the seconds units and tens, 4 and 5 the minutes units and tens, and 6 and 7 the hours units and tens. `seg` and `dig_sel` change in the same cycle.
- R4: The units digits of seconds and minutes count 0 to 9, and their tens digits count 0 to 5. Hundredths run 00 to 99. A pair passes a carry to the next pair only in the enabled cycle in which it wraps to 00, so the next pair moves exactly once per wrap.
- R5: While `run` is low, the displayed digits do not change.
- R6: Hours count 00 to 23. The units digit wraps after 9 when the tens digit is 0 or 1, and after 3 when it is 2. 23:59 followed by one more step gives 00:00.
- R7: Asserting `clr` immediately forces all digits, both dividers and the digit index to zero. While `clr` is held, `dig_sel` is 0, `seg` shows the glyph for 0 and `chime` is 0.
- R8: `chime` is high exactly while the seconds pair reads 59, one clock after the digits change, and low at every other time.
- R9: `seg[6:0]` is {a,b,c,d,e,f,g} with active-high segments. The glyphs are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011. Codes A to F carry the usual hex glyphs.
- R10: With TICK_STAGE=2, each counting enable advances the minutes directly, and the hundredths and seconds stay at 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register runs on this clock |
| clr | input | 1 | Asynchronous clear, active high |
| run | input | 1 | Counting enable; counting is frozen while this is low |
| seg | output | 7 | Segments {a,b,c,d,e,f,g} of the selected digit, active high, registered |
| dig_sel | output | 3 | Index of the digit currently on `seg`, registered |
| chime | output | 1 | High while the seconds read 59, registered |

## Verification
The bench builds two copies of the block with CLK_HZ=1000, CNT_HZ=250 and SCAN_HZ=500. With these values a count step takes four cycles and each digit stays on the display for two cycles. One copy uses TICK_STAGE=0, so thousands of hundredths steps fit in a short run and reach the seconds and minutes carries and the 59-second chime. The second copy uses TICK_STAGE=2, so each step is a minute and the 09, 19 and 23:59 hour wraps take only 1440 steps. Both copies are checked only through their scanned segment output.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;

   localparam int NUM_PAIRS  = 4;
   localparam int NUM_DIGITS = 2 * NUM_PAIRS;
   localparam int SEL_W      = $clog2(NUM_DIGITS);
   localparam int SEG_W      = 7;

   typedef struct packed {
      logic [3:0] tens;
      logic [3:0] units;
   } bcd_pair_t;

   // segment order {a,b,c,d,e,f,g}, active high
   function automatic logic [SEG_W-1:0] seg_glyph(input logic [3:0] v);
      logic [SEG_W-1:0] s;
      case (v)
         4'h0: s = 7'b1111110;
         4'h1: s = 7'b0110000;
         4'h2: s = 7'b1101101;
         4'h3: s = 7'b1111001;
         4'h4: s = 7'b0110011;
         4'h5: s = 7'b1011011;
         4'h6: s = 7'b1011111;
         4'h7: s = 7'b1110000;
         4'h8: s = 7'b1111111;
         4'h9: s = 7'b1111011;
         4'hA: s = 7'b1110111;
         4'hB: s = 7'b0011111;
         4'hC: s = 7'b1001110;
         4'hD: s = 7'b0111101;
         4'hE: s = 7'b1001111;
         default: s = 7'b1000111;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sw_tick_div.sv
module sw_tick_div #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic clr,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or posedge clr) begin
      if (clr)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

endmodule

// File: rtl/sw_bcd_pair.sv
module sw_bcd_pair
   import stopwatch_pkg::*;
#(
   parameter logic [3:0] TOP_TENS  = 4'd5,
   parameter logic [3:0] TOP_UNITS = 4'd9
) (
   input  logic      clk,
   input  logic      clr,
   input  logic      en,
   output bcd_pair_t val,
   output logic      carry
);
   logic at_top;
   logic unit_wrap;

   always_comb begin
      at_top    = (val.tens == TOP_TENS) && (val.units == TOP_UNITS);
      unit_wrap = (val.units == 4'd9);
      carry     = en && at_top;
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         val <= '0;
      end else if (en) begin
         if (at_top) begin
            val <= '0;
         end else if (unit_wrap) begin
            val.units <= 4'd0;
            val.tens  <= val.tens + 4'd1;
         end else begin
            val.units <= val.units + 4'd1;
         end
      end
   end

endmodule

// File: rtl/sw_scan_mux.sv
module sw_scan_mux
   import stopwatch_pkg::*;
(
   input  logic                    clk,
   input  logic                    clr,
   input  logic                    scan_tick,
   input  logic [NUM_DIGITS*4-1:0] digits,
   output logic [SEG_W-1:0]        seg,
   output logic [SEL_W-1:0]        dig_sel
);
   logic [SEL_W-1:0] idx;

   always_ff @(posedge clk or posedge clr) begin
      if (clr)            idx <= '0;
      else if (scan_tick) idx <= idx + 1'b1;
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         dig_sel <= '0;
         seg     <= seg_glyph(4'd0);
      end else begin
         dig_sel <= idx;
         seg     <= seg_glyph(digits[idx*4 +: 4]);
      end
   end

endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
   import stopwatch_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 10_000_000,
   parameter int unsigned CNT_HZ     = 100,
   parameter int unsigned SCAN_HZ    = 1000,
   parameter int unsigned TICK_STAGE = 0
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             run,
   output logic [SEG_W-1:0] seg,
   output logic [SEL_W-1:0] dig_sel,
   output logic             chime
);
   localparam int unsigned CNT_DIV  = CLK_HZ / CNT_HZ;
   localparam int unsigned SCAN_DIV = CLK_HZ / SCAN_HZ;

   if (CNT_HZ == 0 || CLK_HZ % CNT_HZ != 0 || CNT_DIV < 2) begin : g_bad_cnt
      $error("CLK_HZ must be a multiple of CNT_HZ, at least twice");
   end
   if (SCAN_HZ == 0 || CLK_HZ % SCAN_HZ != 0 || SCAN_DIV < 2) begin : g_bad_scan
      $error("CLK_HZ must be a multiple of SCAN_HZ, at least twice");
   end
   if (TICK_STAGE >= NUM_PAIRS) begin : g_bad_stage
      $error("TICK_STAGE out of range");
   end

   logic                    cnt_tick;
   logic                    scan_tick;
   logic                    cnt_adv;
   logic [NUM_PAIRS-1:0]    stage_en;
   logic [NUM_PAIRS-1:0]    carry;
   logic [NUM_DIGITS*4-1:0] digits;
   logic                    day_wrap;

   sw_tick_div #(.DIV(CNT_DIV)) u_cnt_div (
      .clk (clk), .clr (clr), .tick (cnt_tick)
   );

   sw_tick_div #(.DIV(SCAN_DIV)) u_scan_div (
      .clk (clk), .clr (clr), .tick (scan_tick)
   );

   assign cnt_adv  = cnt_tick & run;
   assign day_wrap = carry[NUM_PAIRS-1];

   for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
      localparam logic [3:0] TT = (g == 0) ? 4'd9 : (g == NUM_PAIRS-1) ? 4'd2 : 4'd5;
      localparam logic [3:0] TU = (g == NUM_PAIRS-1) ? 4'd3 : 4'd9;
      bcd_pair_t pv;

      if (g == TICK_STAGE) begin : g_entry
         assign stage_en[g] = cnt_adv;
      end else if (g > TICK_STAGE) begin : g_chain
         assign stage_en[g] = carry[g-1];
      end else begin : g_idle
         assign stage_en[g] = 1'b0;
      end

      sw_bcd_pair #(.TOP_TENS(TT), .TOP_UNITS(TU)) u_pair (
         .clk   (clk),
         .clr   (clr),
         .en    (stage_en[g]),
         .val   (pv),
         .carry (carry[g])
      );

      assign digits[g*8 +: 8] = pv;
   end

   sw_scan_mux u_scan (
      .clk       (clk),
      .clr       (clr),
      .scan_tick (scan_tick),
      .digits    (digits),
      .seg       (seg),
      .dig_sel   (dig_sel)
   );

   always_ff @(posedge clk or posedge clr) begin
      if (clr) chime <= 1'b0;
      else     chime <= (digits[15:8] == 8'h59);
   end

endmodule

// File: rtl/sw_core_chk.sv
module sw_core_chk #(
   parameter int unsigned TICK_STAGE = 0
) (
   input logic        clk,
   input logic        clr,
   input logic        run,
   input logic        cnt_tick,
   input logic [2:0]  dig_sel,
   input logic        chime,
   input logic [31:0] digits,
   input logic        day_wrap
);
   // R2: the index only ever moves up by one, modulo 8
   a_r2_sel_step: assert property (@(posedge clk) disable iff (clr)
      (dig_sel != $past(dig_sel)) |-> (dig_sel == 3'($past(dig_sel) + 3'd1)));

   // R1 / R5: digits move only after an enabled counting tick
   a_r5_hold: assert property (@(posedge clk) disable iff (clr)
      !(cnt_tick && run) |=> $stable(digits));

   // R4: legal seconds and minutes digits
   a_r4_range: assert property (@(posedge clk) disable iff (clr)
      (digits[11:8] <= 4'd9) && (digits[15:12] <= 4'd5) &&
      (digits[19:16] <= 4'd9) && (digits[23:20] <= 4'd5));

   // R6: legal hours
   a_r6_hour_range: assert property (@(posedge clk) disable iff (clr)
      (digits[31:28] <= 4'd2) && ((digits[31:28] == 4'd2) -> (digits[27:24] <= 4'd3)));

   // R6: a day wrap clears hours and minutes
   a_r6_day_wrap: assert property (@(posedge clk) disable iff (clr)
      day_wrap |=> (digits[31:16] == 16'h0000));

   // R8: chime edges follow the seconds reading 59
   a_r8_chime_rise: assert property (@(posedge clk) disable iff (clr)
      $rose(chime) |-> ($past(digits[15:8]) == 8'h59));
   a_r8_chime_fall: assert property (@(posedge clk) disable iff (clr)
      $fell(chime) |-> ($past(digits[15:8]) != 8'h59));

   if (TICK_STAGE == 0) begin : g_sub
      // R4: seconds advance only out of a hundredths wrap
      a_r4_carry_once: assert property (@(posedge clk) disable iff (clr)
         (digits[11:8] != $past(digits[11:8])) |-> ($past(digits[7:0]) == 8'h99));
   end

endmodule

bind stopwatch_core sw_core_chk #(.TICK_STAGE(TICK_STAGE)) u_chk (
   .clk      (clk),
   .clr      (clr),
   .run      (run),
   .cnt_tick (cnt_tick),
   .dig_sel  (dig_sel),
   .chime    (chime),
   .digits   (digits),
   .day_wrap (day_wrap)
);

// File: tb/stopwatch_core_bench.sv
module stopwatch_core_bench;

   logic clk = 1'b0;
   logic clr = 1'b1;
   logic run_a = 1'b0;
   logic run_b = 1'b0;
   logic [6:0] seg_a, seg_b;
   logic [2:0] sel_a, sel_b;
   logic chime_a, chime_b;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   stopwatch_core #(.CLK_HZ(1000), .CNT_HZ(250), .SCAN_HZ(500), .TICK_STAGE(0)) u_stopwatch_core (
      .clk(clk), .clr(clr), .run(run_a), .seg(seg_a), .dig_sel(sel_a), .chime(chime_a)
   );

   stopwatch_core #(.CLK_HZ(1000), .CNT_HZ(250), .SCAN_HZ(500), .TICK_STAGE(2)) u_stopwatch_core_hr (
      .clk(clk), .clr(clr), .run(run_b), .seg(seg_b), .dig_sel(sel_b), .chime(chime_b)
   );

   localparam int STEP_CYC = 4;

   // copy A: ticks to add, expected {hrT,hrU,minT,minU,secT,secU,tenth,hund}, chime
   localparam int          NA = 6;
   localparam int          A_TICKS [NA] = '{1, 8, 91, 5899, 1, 12345};
   localparam logic [31:0] A_EXP   [NA] = '{32'h00000001, 32'h00000009, 32'h00000100,
                                            32'h00005999, 32'h00010000, 32'h00030345};
   localparam bit          A_CHM   [NA] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

   // copy B: each tick is one minute
   localparam int          NB = 6;
   localparam int          B_TICKS [NB] = '{59, 1, 540, 600, 239, 1};
   localparam logic [31:0] B_EXP   [NB] = '{32'h00590000, 32'h01000000, 32'h10000000,
                                            32'h20000000, 32'h23590000, 32'h00000000};

   function automatic logic [6:0] glyph(input int v);
      case (v)
         0: return 7'b1111110;  1: return 7'b0110000;
         2: return 7'b1101101;  3: return 7'b1111001;
         4: return 7'b0110011;  5: return 7'b1011011;
         6: return 7'b1011111;  7: return 7'b1110000;
         8: return 7'b1111111;  9: return 7'b1111011;
         default: return 7'b0000000;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // scan one copy for 20 cycles, rebuilding the eight digits from the segments
   task automatic read_disp(input bit use_b, output logic [31:0] got, output bit scan_ok);
      bit [7:0] seen = '0;
      int run_len = 0;
      bit moved = 1'b0;
      logic [2:0] prev = 3'd0;
      got = 32'hFFFF_FFFF;
      scan_ok = 1'b1;
      for (int c = 0; c < 20; c++) begin
         logic [6:0] s;
         logic [2:0] d;
         int val;
         @(negedge clk);
         s = use_b ? seg_b : seg_a;
         d = use_b ? sel_b : sel_a;
         val = 15;
         for (int v = 0; v < 10; v++) if (glyph(v) == s) val = v;
         got[d*4 +: 4] = 4'(val);
         seen[d] = 1'b1;
         if (c > 0) begin
            if (d != prev) begin
               if (d != 3'(prev + 3'd1)) scan_ok = 1'b0;
               if (moved && run_len != 2) scan_ok = 1'b0;
               moved = 1'b1;
               run_len = 1;
            end else begin
               run_len++;
            end
         end else begin
            run_len = 1;
         end
         prev = d;
      end
      if (seen != 8'hFF) scan_ok = 1'b0;
   endtask

   task automatic advance(input bit use_b, input int ticks);
      @(negedge clk);
      if (use_b) run_b = 1'b1; else run_a = 1'b1;
      repeat (ticks * STEP_CYC) @(posedge clk);
      @(negedge clk);
      run_a = 1'b0;
      run_b = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] got, got2;
      bit sok;

      // R7: state while clear is held
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(sel_a == 3'd0 && sel_b == 3'd0, "R7", "sel under clear", {29'd0, sel_a}, 32'd0);
      check(seg_a == glyph(0) && seg_b == glyph(0), "R7", "seg under clear", {25'd0, seg_a}, {25'd0, glyph(0)});
      check(!chime_a && !chime_b, "R7", "chime under clear", {31'd0, chime_a}, 32'd0);
      clr = 1'b0;

      // R2, R3, R9: initial scan shows zeros in every position
      read_disp(1'b0, got, sok);
      check(got == 32'h0, "R9", "digits after release", got, 32'h0);
      check(sok, "R2", "scan order and dwell", {31'd0, sok}, 32'd1);

      // R1, R3, R4, R8: vector walk on the hundredths-entry copy
      for (int i = 0; i < NA; i++) begin
         advance(1'b0, A_TICKS[i]);
         read_disp(1'b0, got, sok);
         check(got == A_EXP[i], "R4", $sformatf("A vector %0d digits (R1 R3)", i), got, A_EXP[i]);
         check(chime_a == A_CHM[i], "R8", $sformatf("A vector %0d chime", i), {31'd0, chime_a}, {31'd0, A_CHM[i]});
         check(sok, "R2", $sformatf("A vector %0d scan", i), {31'd0, sok}, 32'd1);
      end

      // R5: with run low nothing moves across many count periods
      repeat (37) @(negedge clk);
      read_disp(1'b0, got2, sok);
      check(got2 == A_EXP[NA-1], "R5", "frozen while run low", got2, A_EXP[NA-1]);

      // R6, R10: minute-entry copy through every hours boundary
      for (int i = 0; i < NB; i++) begin
         advance(1'b1, B_TICKS[i]);
         read_disp(1'b1, got, sok);
         check(got == B_EXP[i], "R6", $sformatf("B vector %0d digits (R10)", i), got, B_EXP[i]);
      end
      check(!chime_b, "R10", "no chime with minute entry", {31'd0, chime_b}, 32'd0);

      // R7: clear in the middle of counting
      @(negedge clk);
      run_a = 1'b1;
      repeat (10) @(negedge clk);
      clr = 1'b1;
      run_a = 1'b0;
      #1;
      check(sel_a == 3'd0 && seg_a == glyph(0) && !chime_a, "R7", "async clear outputs",
            {22'd0, sel_a, seg_a}, {22'd0, 3'd0, glyph(0)});
      @(negedge clk);
      clr = 1'b0;
      read_disp(1'b0, got, sok);
      check(got == 32'h0, "R7", "digits after mid-run clear", got, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule